// File: doc/BRIEF.md
# Regulator Soft-Start Sequencer

This block orders the start-up of a single-phase buck regulator. It waits until the supply has cleared undervoltage lockout and the overcurrent threshold setup has finished. It then raises a digital reference code in steps of one LSB from zero to a target code, which stands for 800 mV by default. The error amplifier tracks this code, so the output charges linearly and inrush current stays low. The ramp length is set by two parameters: the target code and the number of clock cycles per LSB step.

While the ramp runs, the low-side gate enable stays off until the modulator reports the first high-side pulse. A pre-biased output then cannot be pulled down through the inductor. If the output starts above target, the high side never fires, and the low side is released when the ramp completes. An overcurrent report at any point stops the ramp and latches a PWM shutdown that only power-on reset clears. The low-side mask belongs to the regulation loop only, so a protection request can still turn the low side on in every state. A disable request sends the sequencer back to idle, and releasing it starts a fresh ramp.

Top module: `softstart_seq`

## Requirements
- R1: The ramp starts on the clock edge at which `uvlo_ok` and `ocset_done` are both high and `dis_req` is low. While either of the first two is low, `ref_code` stays 0. If `uvlo_ok` falls during the ramp, the sequencer returns to idle with `ref_code` at 0.
- R2: After the starting edge, `ref_code` rises by exactly one every STEP_CYCLES clock edges. The first increment comes STEP_CYCLES edges after the starting edge, so k edges after the start the code is min(floor(k/STEP_CYCLES), TARGET_CODE).
- R3: During the ramp, `ls_enable` is low until `hs_pulse` has been sampled high at a clock edge. From that edge on, `ls_enable` is high for the rest of the ramp.
- R4: If no `hs_pulse` arrives during the ramp, `ls_enable` goes high on the same edge that `ss_done` rises.
- R5: An `oc_fault` sampled high in any state latches shutdown. `pwm_shutdown` goes high, `ref_code` keeps the value it had before that edge, and `ss_done` and the loop's `ls_enable` go low. Neither `dis_req` nor `uvlo_ok` clears this state; only `rst_n` does.
- R6: `prot_ls_on` high forces `ls_enable` high in every state, including latched shutdown, without waiting for a clock edge.
- R7: `ss_done` rises on the edge at which `ref_code` reaches TARGET_CODE. After that, `ref_code` holds TARGET_CODE until a disable, a loss of `uvlo_ok`, a fault or a reset.
- R8: `dis_req` high returns the sequencer to idle on the next edge, with `ref_code` at 0 and `ss_done` low. Releasing it while the start conditions hold begins a new ramp from 0.
- R9: After reset, `ref_code` is 0 and `ss_done`, `pwm_shutdown` and `ls_enable` are low (with `prot_ls_on` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; the only way out of latched shutdown |
| uvlo_ok | input | 1 | Supply above undervoltage lockout |
| ocset_done | input | 1 | Overcurrent threshold setup finished |
| hs_pulse | input | 1 | High-side PWM pulse seen in this cycle |
| oc_fault | input | 1 | Overcurrent event from the protection logic |
| dis_req | input | 1 | Disable request |
| prot_ls_on | input | 1 | Protection request to turn the low side on, bypassing the start-up mask |
| ref_code | output | REF_W | Reference code for the error amplifier |
| ls_enable | output | 1 | Low-side driver enable |
| ss_done | output | 1 | Ramp complete; enables power-good evaluation |
| pwm_shutdown | output | 1 | Latched overcurrent shutdown of the PWM and both gates |

## Verification
A clean ramp with no high-side activity is compared cycle by cycle against the arithmetic staircase. This run shows whether the step spacing, the final code and the pre-bias release of the low side are correct. A sweep places a single high-side pulse at every cycle of the ramp, which separates the unmask edge from both the ramp position and the completion edge. A second sweep injects an overcurrent at every cycle of the ramp, confirming the code freezes at its value before the fault and that disable and supply loss cannot clear the latch. Separate runs toggle disable and supply loss mid-ramp and after completion, and assert the protection override while the low side is masked and while shutdown is latched.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;
    typedef enum logic [1:0] {
        SS_IDLE  = 2'd0,
        SS_RAMP  = 2'd1,
        SS_DONE  = 2'd2,
        SS_FAULT = 2'd3
    } ss_state_e;
endpackage

// File: rtl/ss_step_timer.sv
module ss_step_timer #(
    parameter int STEP_CYCLES = 562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic step_tick
);
    localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        step_tick = run && (r_q.cnt == LAST);
        if (!run || step_tick) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LAST); // R2
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> r_q.cnt == '0); // R2
endmodule

// File: rtl/ss_ramp_fsm.sv
module ss_ramp_fsm
    import ss_seq_pkg::*;
#(
    parameter int TARGET_CODE = 800,
    parameter int REF_W       = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uvlo_ok,
    input  logic             ocset_done,
    input  logic             dis_req,
    input  logic             oc_fault,
    input  logic             hs_pulse,
    input  logic             step_tick,
    output ss_state_e        state_o,
    output logic [REF_W-1:0] ref_o,
    output logic             hs_seen_o
);
    localparam logic [REF_W-1:0] TOP = REF_W'(TARGET_CODE);

    typedef struct packed {
        ss_state_e        st;
        logic [REF_W-1:0] ref_val;
        logic             hs_seen;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.st == SS_FAULT) begin
            r_d = r_q;
        end else if (oc_fault) begin
            r_d.st = SS_FAULT;
        end else if (dis_req || !uvlo_ok) begin
            r_d.st      = SS_IDLE;
            r_d.ref_val = '0;
            r_d.hs_seen = 1'b0;
        end else begin
            unique case (r_q.st)
                SS_IDLE: begin
                    r_d.ref_val = '0;
                    r_d.hs_seen = 1'b0;
                    if (ocset_done) r_d.st = SS_RAMP;
                end
                SS_RAMP: begin
                    if (hs_pulse) r_d.hs_seen = 1'b1;
                    if (step_tick) begin
                        r_d.ref_val = r_q.ref_val + 1'b1;
                        if (r_q.ref_val + 1'b1 == TOP) r_d.st = SS_DONE;
                    end
                end
                SS_DONE: r_d = r_q;
                default: r_d.st = SS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= SS_IDLE;
            r_q.ref_val <= '0;
            r_q.hs_seen <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o   = r_q.st;
    assign ref_o     = r_q.ref_val;
    assign hs_seen_o = r_q.hs_seen;

    AST_REF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ref_val <= TOP); // R2
    AST_REF_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SS_RAMP && $past(r_q.st) == SS_RAMP)
            |-> (r_q.ref_val - $past(r_q.ref_val)) <= 1); // R2
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == SS_FAULT |=> r_q.st == SS_FAULT); // R5
    AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == SS_FAULT |=> $stable(r_q.ref_val)); // R5
    AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SS_IDLE && !(uvlo_ok && ocset_done)) |=> r_q.st != SS_RAMP); // R1
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_req && !oc_fault && r_q.st != SS_FAULT) |=> r_q.ref_val == '0); // R8
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
    import ss_seq_pkg::*;
#(
    parameter int TARGET_CODE = 800,
    parameter int STEP_CYCLES = 562,
    localparam int REF_W = $clog2(TARGET_CODE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uvlo_ok,
    input  logic             ocset_done,
    input  logic             hs_pulse,
    input  logic             oc_fault,
    input  logic             dis_req,
    input  logic             prot_ls_on,
    output logic [REF_W-1:0] ref_code,
    output logic             ls_enable,
    output logic             ss_done,
    output logic             pwm_shutdown
);
    ss_state_e state;
    logic      step_tick;
    logic      hs_seen;
    logic      loop_ls;

    ss_step_timer #(
        .STEP_CYCLES(STEP_CYCLES)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state == SS_RAMP),
        .step_tick(step_tick)
    );

    ss_ramp_fsm #(
        .TARGET_CODE(TARGET_CODE),
        .REF_W      (REF_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .uvlo_ok   (uvlo_ok),
        .ocset_done(ocset_done),
        .dis_req   (dis_req),
        .oc_fault  (oc_fault),
        .hs_pulse  (hs_pulse),
        .step_tick (step_tick),
        .state_o   (state),
        .ref_o     (ref_code),
        .hs_seen_o (hs_seen)
    );

    always_comb begin
        unique case (state)
            SS_RAMP: loop_ls = hs_seen;
            SS_DONE: loop_ls = 1'b1;
            default: loop_ls = 1'b0;
        endcase
        ls_enable    = prot_ls_on | loop_ls;
        ss_done      = (state == SS_DONE);
        pwm_shutdown = (state == SS_FAULT);
    end

    AST_DONE_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> ref_code == REF_W'(TARGET_CODE)); // R7
    AST_DONE_LS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> ls_enable); // R4
    AST_SHUT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_shutdown && !prot_ls_on) |-> (!ls_enable && !ss_done)); // R5
    AST_PROT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        prot_ls_on |-> ls_enable); // R6
endmodule

// File: tb/softstart_seq_tb_top.sv
module softstart_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int T  = 12;
    localparam int S  = 3;
    localparam int RW = $clog2(T + 1);
    localparam int RAMP_LEN = T * S;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uvlo_ok = 1'b0, ocset_done = 1'b0, hs_pulse = 1'b0;
    logic oc_fault = 1'b0, dis_req = 1'b0, prot_ls_on = 1'b0;
    logic [RW-1:0] ref_code;
    logic ls_enable, ss_done, pwm_shutdown;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    softstart_seq #(
        .TARGET_CODE(T),
        .STEP_CYCLES(S)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .uvlo_ok     (uvlo_ok),
        .ocset_done  (ocset_done),
        .hs_pulse    (hs_pulse),
        .oc_fault    (oc_fault),
        .dis_req     (dis_req),
        .prot_ls_on  (prot_ls_on),
        .ref_code    (ref_code),
        .ls_enable   (ls_enable),
        .ss_done     (ss_done),
        .pwm_shutdown(pwm_shutdown)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_ref(input int k);
        return (k / S >= T) ? T : k / S;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; uvlo_ok = 1'b0; ocset_done = 1'b0; hs_pulse = 1'b0;
        oc_fault = 1'b0; dis_req = 1'b0; prot_ls_on = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic start_ramp();
        uvlo_ok = 1'b1; ocset_done = 1'b1;
        step();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // R9 reset state
        do_reset();
        chk("R9 ref", int'(ref_code), 0);
        chk("R9 ss_done", int'(ss_done), 0);
        chk("R9 shutdown", int'(pwm_shutdown), 0);
        chk("R9 ls", int'(ls_enable), 0);

        // R1 start gating
        uvlo_ok = 1'b1; ocset_done = 1'b0;
        repeat (2 * S) step();
        chk("R1 no start without ocset_done", int'(ref_code), 0);
        uvlo_ok = 1'b0; ocset_done = 1'b1;
        repeat (2 * S) step();
        chk("R1 no start without uvlo_ok", int'(ref_code), 0);
        start_ramp();
        repeat (S) step();
        chk("R1 start when both high", int'(ref_code), 1);
        repeat (2) step();
        uvlo_ok = 1'b0;
        step();
        chk("R1 uvlo loss returns idle", int'(ref_code), 0);
        repeat (2 * S) step();
        chk("R1 stays idle", int'(ref_code), 0);

        // R2 R4 R7 clean ramp, no high-side pulse
        do_reset();
        start_ramp();
        for (int k = 0; k <= RAMP_LEN + 4; k++) begin
            chk("R2 ramp code", int'(ref_code), exp_ref(k));
            chk("R7 ss_done", int'(ss_done), int'(k >= RAMP_LEN));
            chk("R4 prebias ls release", int'(ls_enable), int'(k >= RAMP_LEN));
            step();
        end

        // R3 single high-side pulse at every ramp cycle
        for (int p = 0; p < RAMP_LEN; p++) begin
            do_reset();
            start_ramp();
            for (int k = 0; k <= RAMP_LEN + 1; k++) begin
                chk("R3 ls unmask", int'(ls_enable), int'(k > p || k >= RAMP_LEN));
                chk("R2 ramp with hs", int'(ref_code), exp_ref(k));
                hs_pulse = (k == p);
                step();
            end
            hs_pulse = 1'b0;
        end

        // R5 overcurrent at every ramp cycle
        for (int p = 0; p <= RAMP_LEN; p++) begin
            do_reset();
            start_ramp();
            for (int k = 0; k <= RAMP_LEN + 2; k++) begin
                if (k <= p) begin
                    chk("R5 pre-fault code", int'(ref_code), exp_ref(k));
                    chk("R5 pre-fault shutdown", int'(pwm_shutdown), 0);
                end else begin
                    chk("R5 frozen code", int'(ref_code), exp_ref(p));
                    chk("R5 shutdown", int'(pwm_shutdown), 1);
                    chk("R5 ss_done low", int'(ss_done), 0);
                    chk("R5 ls off", int'(ls_enable), 0);
                end
                oc_fault = (k == p);
                step();
            end
            oc_fault = 1'b0;
            dis_req = 1'b1; step(); dis_req = 1'b0; step();
            uvlo_ok = 1'b0; step(); uvlo_ok = 1'b1; step();
            chk("R5 latch survives disable and uvlo", int'(pwm_shutdown), 1);
            chk("R5 code held", int'(ref_code), exp_ref(p));
        end
        do_reset();
        chk("R5 reset clears latch", int'(pwm_shutdown), 0);

        // R8 disable mid-ramp and after completion
        start_ramp();
        repeat (5) step();
        chk("R8 mid-ramp code", int'(ref_code), exp_ref(5));
        dis_req = 1'b1;
        step();
        chk("R8 disable zeroes code", int'(ref_code), 0);
        chk("R8 disable ss_done", int'(ss_done), 0);
        repeat (3) step();
        chk("R8 disable holds idle", int'(ref_code), 0);
        dis_req = 1'b0;
        step();
        chk("R8 restart from zero", int'(ref_code), 0);
        repeat (S) step();
        chk("R8 restart first step", int'(ref_code), 1);
        repeat (RAMP_LEN - S) step();
        chk("R8 restart completes", int'(ss_done), 1);
        dis_req = 1'b1;
        step();
        chk("R8 disable after done code", int'(ref_code), 0);
        chk("R8 disable after done ss_done", int'(ss_done), 0);
        chk("R8 disable after done ls", int'(ls_enable), 0);
        dis_req = 1'b0;

        // R6 protection override
        do_reset();
        start_ramp();
        step();
        chk("R6 masked before override", int'(ls_enable), 0);
        prot_ls_on = 1'b1; #1;
        chk("R6 override during mask", int'(ls_enable), 1);
        prot_ls_on = 1'b0; #1;
        chk("R6 override released", int'(ls_enable), 0);
        oc_fault = 1'b1;
        step();
        oc_fault = 1'b0;
        chk("R6 fault ls off", int'(ls_enable), 0);
        prot_ls_on = 1'b1; #1;
        chk("R6 override in shutdown", int'(ls_enable), 1);
        prot_ls_on = 1'b0;
        step();

        finish_run();
    end
endmodule